// File: doc/BRIEF.md
# Mixed-Semantics Peripheral Register File

This block is the memory-mapped register slave of a small device controller. A bus master reaches it through a single-cycle port: one address, a write strobe with write data, and a read strobe. Read data is registered and appears one clock after the read strobe. Each address in the map applies its own side-effect rule instead of acting as plain storage:

- write-one-to-clear interrupt flags
- set and clear aliases for the interrupt enables and for a general output word
- a write-triggered command doorbell
- a receive queue that pops on read
- a counter that is snapshotted on read
- an event word that is cleared on read

The device side raises interrupt flags and events, pushes receive bytes and advances the counter. The block drives the output word, a one-cycle command pulse and a level interrupt line. Software never needs a read-modify-write, because every single-bit change has its own address. A soft-reset bit returns the whole register file to its reset state without the global reset.

The address is a word index; the low four bits select the register. An access whose upper address bits are non-zero hits nothing. The register indices are:

| Index | Name | Behaviour |
|---|---|---|
| 0 | control | Read/write. Bit 0 is the global interrupt enable, bit 1 is soft reset. |
| 1 | interrupt flags | Read; write-one-to-clear. |
| 2 | enable set | Reads the enables. |
| 3 | enable clear | Reads the enables. |
| 4 | output word | Read-only. |
| 5 | output set | Reads the output word. |
| 6 | output clear | Reads the output word. |
| 7 | doorbell | Write-triggered. |
| 8 | receive data | Pops on read. |
| 9 | receive level | Read-only. |
| 10 | live counter | Read captures a snapshot. |
| 11 | held snapshot | Read-only. |
| 12 | event word | Read-only; cleared on read. |
| 13 to 15 | unmapped | Read zero. |

Top module: `mmio_regbank`

## Requirements
- R1: A hardware pulse on a bit of `hw_irq_set` sets that interrupt flag. A write to index 1 clears exactly the flags whose data bits are 1, and flags written 0 keep their value.
- R2: When a flag is raised by hardware in the same cycle that a write to index 1 clears it, the flag ends up set.
- R3: A write to index 2 sets the enable bits written 1, and a write to index 3 clears the enable bits written 1. In both cases the bits written 0 are unchanged, and a read of either index returns the enable word.
- R4: A write to index 5 sets the bits of the output word written 1, and a write to index 6 clears the bits written 1. The other bits are unchanged, and `gpio_out` reflects the word in the cycle after the write.
- R5: Any write to index 7 drives `cmd_pulse` high for exactly the one cycle after the write, and stores nothing. A read of index 7 returns 0.
- R6: A read of index 8 returns the oldest receive byte and removes it. A read while the queue is empty returns 0 and removes nothing. A push into a full queue is dropped. Index 9 reads the number of stored bytes.
- R7: A read of index 10 returns the counter value at that read edge and stores it as a snapshot. Index 11 returns that snapshot, which stays unchanged while the counter keeps advancing on `cnt_inc`.
- R8: A read of index 12 returns the event word and clears it. An event bit pulsed in the same cycle as that read is set afterwards.
- R9: Writes to the read-only indices 4, 9, 11 and 12 change no state.
- R10: `irq` is high exactly when control bit 0 is 1 and at least one flag is set whose enable bit is also set.
- R11: Writing 1 to control bit 1 sets a soft-reset bit. On the next edge, every register, the queue and the counter return to their reset values and the bit clears itself. A read in the cycle between those two edges shows the bit as 1.
- R12: After reset every register reads 0, and `gpio_out`, `cmd_pulse`, `irq` and `bus_rdata` are 0. Reads of unmapped indices return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Word address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | DATA_W | Read data, valid the cycle after `bus_rd` and held until the next read |
| hw_irq_set | input | IRQ_W | Per-bit pulses that raise interrupt flags |
| hw_evt | input | EVT_W | Per-bit pulses that raise event bits |
| rx_push | input | 1 | Push `rx_byte` into the receive queue |
| rx_byte | input | RX_W | Receive byte |
| cnt_inc | input | 1 | Advance the free-running counter by one |
| gpio_out | output | OUT_W | Output data word |
| cmd_pulse | output | 1 | One-cycle doorbell pulse |
| irq | output | 1 | Level interrupt request |

## Verification
The bench goes after the same-cycle collisions: a hardware flag landing on a write-one-to-clear, and an event landing on the clearing read. A design that let the bus win would silently lose the event, and the following read would show the bit missing. It reads the empty and overfilled receive queue, where a wrong design would return stale bytes, move its pointer past the data or overwrite the oldest entry. It reads the snapshot while the counter is running, where a design that returns the live count shows a drifting value. It also writes the read-only and doorbell addresses and then reads the state they could have touched, and checks that soft reset clears everything in one cycle and then releases itself instead of holding the block in reset.

// File: rtl/mmio_regbank_pkg.sv
package mmio_regbank_pkg;
   localparam int unsigned REG_IDX_W = 4;

   typedef enum logic [REG_IDX_W-1:0] {
      RB_CTRL    = 4'd0,
      RB_STAT    = 4'd1,
      RB_IEN_SET = 4'd2,
      RB_IEN_CLR = 4'd3,
      RB_OUT_VAL = 4'd4,
      RB_OUT_SET = 4'd5,
      RB_OUT_CLR = 4'd6,
      RB_CMD     = 4'd7,
      RB_RX_DATA = 4'd8,
      RB_RX_LVL  = 4'd9,
      RB_CNT     = 4'd10,
      RB_SNAP    = 4'd11,
      RB_EVT     = 4'd12
   } rb_reg_e;

   localparam int unsigned CTRL_GIE_BIT  = 0;
   localparam int unsigned CTRL_SRST_BIT = 1;
endpackage

// File: rtl/rb_bit_bank.sv
// Bit register with independent per-bit set and clear masks; set has priority.
module rb_bit_bank #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         srst,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] bits_o
);
   if (W < 1) begin : g_bad_w
      $error("rb_bit_bank: W must be at least 1");
   end

   logic [W-1:0] bits_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     bits_q <= '0;
      else if (srst)  bits_q <= '0;
      else            bits_q <= (bits_q & ~clr_i) | set_i;
   end

   assign bits_o = bits_q;

   // R2: a raised bit is present on the next cycle whatever the clear mask was
   p_set_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!srst && (|set_i)) |=> ((bits_o & $past(set_i)) == $past(set_i)));

   // R1: bits outside the clear mask never drop
   p_keep_unmasked_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!srst) |=> ((bits_o & $past(bits_o) & ~$past(clr_i)) == ($past(bits_o) & ~$past(clr_i))));
endmodule

// File: rtl/rb_rx_fifo.sv
// Receive queue: push from the device, pop on bus read, zero when empty.
module rb_rx_fifo #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned W     = 8,
   localparam int unsigned PTR_W = $clog2(DEPTH),
   localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             srst,
   input  logic             push_i,
   input  logic [W-1:0]     data_i,
   input  logic             pop_i,
   output logic [W-1:0]     head_o,
   output logic [LVL_W-1:0] level_o
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("rb_rx_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [LVL_W-1:0] level_q;
   logic             full, empty, push_ok, pop_ok;

   assign full    = (level_q == LVL_W'(DEPTH));
   assign empty   = (level_q == '0);
   assign push_ok = push_i && !full && !srst;
   assign pop_ok  = pop_i && !empty && !srst;

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= data_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         level_q <= '0;
      end else if (srst) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         level_q <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
         if (push_ok && !pop_ok)      level_q <= level_q + 1'b1;
         else if (pop_ok && !push_ok) level_q <= level_q - 1'b1;
      end
   end

   assign head_o  = empty ? '0 : mem[rd_ptr];
   assign level_o = level_q;

   // R6: the level never exceeds the storage
   p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      level_o <= LVL_W'(DEPTH));

   // R6: reading an empty queue leaves it empty
   p_empty_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && empty && !push_i) |=> (level_o == '0));

   // R6: a push into a full queue without a pop is dropped
   p_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && full && !pop_i && !srst) |=> (level_o == LVL_W'(DEPTH)));
endmodule

// File: rtl/rb_snap_counter.sv
// Free-running counter with a snapshot register loaded on capture.
module rb_snap_counter #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         srst,
   input  logic         inc_i,
   input  logic         capture_i,
   output logic [W-1:0] cnt_o,
   output logic [W-1:0] snap_o
);
   if (W < 2) begin : g_bad_w
      $error("rb_snap_counter: W must be at least 2");
   end

   logic [W-1:0] cnt_q, snap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         snap_q <= '0;
      end else if (srst) begin
         cnt_q  <= '0;
         snap_q <= '0;
      end else begin
         if (inc_i)     cnt_q  <= cnt_q + 1'b1;
         if (capture_i) snap_q <= cnt_q;
      end
   end

   assign cnt_o  = cnt_q;
   assign snap_o = snap_q;

   // R7: without a capture the snapshot holds
   p_snap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!srst && !capture_i) |=> $stable(snap_o));

   // R7: a capture stores the count seen at that edge
   p_snap_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!srst && capture_i) |=> (snap_o == $past(cnt_o)));

   // R7: the counter only moves on an increment
   p_cnt_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!srst && !inc_i) |=> $stable(cnt_o));
endmodule

// File: rtl/mmio_regbank.sv
module mmio_regbank
   import mmio_regbank_pkg::*;
#(
   parameter int unsigned ADDR_W     = 6,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned IRQ_W      = 8,
   parameter int unsigned EVT_W      = 8,
   parameter int unsigned OUT_W      = 32,
   parameter int unsigned RX_W       = 8,
   parameter int unsigned FIFO_DEPTH = 4,
   parameter int unsigned CNT_W      = 16,
   localparam int unsigned LVL_W = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [IRQ_W-1:0]  hw_irq_set,
   input  logic [EVT_W-1:0]  hw_evt,
   input  logic              rx_push,
   input  logic [RX_W-1:0]   rx_byte,
   input  logic              cnt_inc,
   output logic [OUT_W-1:0]  gpio_out,
   output logic              cmd_pulse,
   output logic              irq
);
   // elaboration-time parameter checks
   if (ADDR_W < REG_IDX_W) begin : g_bad_addr
      $error("mmio_regbank: ADDR_W too small for the register map");
   end
   if (DATA_W < 2 || IRQ_W > DATA_W || EVT_W > DATA_W || OUT_W > DATA_W ||
       RX_W > DATA_W || CNT_W > DATA_W || LVL_W > DATA_W) begin : g_bad_width
      $error("mmio_regbank: a register is wider than the data bus");
   end

   // ---------------- address decode ----------------
   logic    addr_ok;
   rb_reg_e reg_sel;

   if (ADDR_W > REG_IDX_W) begin : g_wide_addr
      assign addr_ok = ~|bus_addr[ADDR_W-1:REG_IDX_W];
   end else begin : g_exact_addr
      assign addr_ok = 1'b1;
   end

   assign reg_sel = rb_reg_e'(bus_addr[REG_IDX_W-1:0]);

   logic wr_any, rd_any;
   logic wr_ctrl, wr_stat, wr_ien_set, wr_ien_clr, wr_out_set, wr_out_clr;
   logic wr_cmd, wr_out_val;
   logic rd_rx_data, rd_cnt, rd_evt;

   assign wr_any     = bus_wr && addr_ok;
   assign rd_any     = bus_rd && addr_ok;
   assign wr_ctrl    = wr_any && (reg_sel == RB_CTRL);
   assign wr_stat    = wr_any && (reg_sel == RB_STAT);
   assign wr_ien_set = wr_any && (reg_sel == RB_IEN_SET);
   assign wr_ien_clr = wr_any && (reg_sel == RB_IEN_CLR);
   assign wr_out_val = wr_any && (reg_sel == RB_OUT_VAL);
   assign wr_out_set = wr_any && (reg_sel == RB_OUT_SET);
   assign wr_out_clr = wr_any && (reg_sel == RB_OUT_CLR);
   assign wr_cmd     = wr_any && (reg_sel == RB_CMD);
   assign rd_rx_data = rd_any && (reg_sel == RB_RX_DATA);
   assign rd_cnt     = rd_any && (reg_sel == RB_CNT);
   assign rd_evt     = rd_any && (reg_sel == RB_EVT);

   // ---------------- control and doorbell ----------------
   logic gie_q, srst_q, cmd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gie_q  <= 1'b0;
         srst_q <= 1'b0;
      end else if (srst_q) begin
         gie_q  <= 1'b0;
         srst_q <= 1'b0;
      end else if (wr_ctrl) begin
         gie_q  <= bus_wdata[CTRL_GIE_BIT];
         srst_q <= bus_wdata[CTRL_SRST_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmd_q <= 1'b0;
      else        cmd_q <= wr_cmd && !srst_q;
   end

   // ---------------- bit registers ----------------
   logic [IRQ_W-1:0] stat_q, ien_q;
   logic [EVT_W-1:0] evt_q;
   logic [OUT_W-1:0] out_q;

   rb_bit_bank #(.W(IRQ_W)) u_stat (
      .clk(clk), .rst_n(rst_n), .srst(srst_q),
      .set_i(hw_irq_set),
      .clr_i(wr_stat ? bus_wdata[IRQ_W-1:0] : '0),
      .bits_o(stat_q));

   rb_bit_bank #(.W(IRQ_W)) u_ien (
      .clk(clk), .rst_n(rst_n), .srst(srst_q),
      .set_i(wr_ien_set ? bus_wdata[IRQ_W-1:0] : '0),
      .clr_i(wr_ien_clr ? bus_wdata[IRQ_W-1:0] : '0),
      .bits_o(ien_q));

   rb_bit_bank #(.W(OUT_W)) u_out (
      .clk(clk), .rst_n(rst_n), .srst(srst_q),
      .set_i(wr_out_set ? bus_wdata[OUT_W-1:0] : '0),
      .clr_i(wr_out_clr ? bus_wdata[OUT_W-1:0] : '0),
      .bits_o(out_q));

   rb_bit_bank #(.W(EVT_W)) u_evt (
      .clk(clk), .rst_n(rst_n), .srst(srst_q),
      .set_i(hw_evt),
      .clr_i(rd_evt ? '1 : '0),
      .bits_o(evt_q));

   // ---------------- receive queue and counter ----------------
   logic [RX_W-1:0]  rx_head;
   logic [LVL_W-1:0] rx_level;
   logic [CNT_W-1:0] cnt_val, snap_val;

   rb_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(RX_W)) u_rxq (
      .clk(clk), .rst_n(rst_n), .srst(srst_q),
      .push_i(rx_push), .data_i(rx_byte), .pop_i(rd_rx_data),
      .head_o(rx_head), .level_o(rx_level));

   rb_snap_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .srst(srst_q),
      .inc_i(cnt_inc), .capture_i(rd_cnt),
      .cnt_o(cnt_val), .snap_o(snap_val));

   // ---------------- read path ----------------
   logic [DATA_W-1:0] rd_mux, rdata_q;

   always_comb begin
      case (reg_sel)
         RB_CTRL:                          rd_mux = DATA_W'({srst_q, gie_q});
         RB_STAT:                          rd_mux = DATA_W'(stat_q);
         RB_IEN_SET, RB_IEN_CLR:           rd_mux = DATA_W'(ien_q);
         RB_OUT_VAL, RB_OUT_SET, RB_OUT_CLR: rd_mux = DATA_W'(out_q);
         RB_RX_DATA:                       rd_mux = DATA_W'(rx_head);
         RB_RX_LVL:                        rd_mux = DATA_W'(rx_level);
         RB_CNT:                           rd_mux = DATA_W'(cnt_val);
         RB_SNAP:                          rd_mux = DATA_W'(snap_val);
         RB_EVT:                           rd_mux = DATA_W'(evt_q);
         default:                          rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (bus_rd) rdata_q <= addr_ok ? rd_mux : '0;
   end

   assign bus_rdata = rdata_q;
   assign gpio_out  = out_q;
   assign cmd_pulse = cmd_q;
   assign irq       = gie_q && (|(stat_q & ien_q));

   // R5: a doorbell pulse only follows a doorbell write
   p_cmd_from_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_pulse |-> $past(wr_cmd));

   // R11: soft reset releases itself after one cycle
   p_srst_selfclear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      srst_q |=> (!srst_q && gpio_out == '0 && !irq));

   // R10: no interrupt while the global enable is off
   p_irq_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !gie_q |-> !irq);

   // R9: a write to the read-only output view changes nothing
   p_ro_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_out_val && !srst_q) |=> $stable(gpio_out));
endmodule

// File: tb/sim_mmio_regbank.sv
`timescale 1ns/1ps
module sim_mmio_regbank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;
   logic [7:0]  hw_irq_set = '0;
   logic [7:0]  hw_evt = '0;
   logic        rx_push = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic        cnt_inc = 1'b0;
   logic [31:0] gpio_out;
   logic        cmd_pulse;
   logic        irq;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   mmio_regbank u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .hw_irq_set(hw_irq_set), .hw_evt(hw_evt), .rx_push(rx_push),
      .rx_byte(rx_byte), .cnt_inc(cnt_inc), .gpio_out(gpio_out),
      .cmd_pulse(cmd_pulse), .irq(irq));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // all tasks start and end at a falling edge
   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] v);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      v = bus_rdata;
   endtask

   task automatic rd_chk(input string tag, input logic [5:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      chk(tag, v, exp);
   endtask

   task automatic irq_pulse(input logic [7:0] v);
      hw_irq_set = v; @(negedge clk); hw_irq_set = '0;
   endtask

   task automatic evt_pulse(input logic [7:0] v);
      hw_evt = v; @(negedge clk); hw_evt = '0;
   endtask

   task automatic push(input logic [7:0] b);
      rx_push = 1'b1; rx_byte = b; @(negedge clk); rx_push = 1'b0;
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   // {is_write, index, data, expected read}
   localparam int NV = 14;
   localparam logic [68:0] TBL [NV] = '{
      {1'b1, 4'd2,  32'h0000000F, 32'h0},
      {1'b0, 4'd2,  32'h0,        32'h0000000F},
      {1'b1, 4'd3,  32'h00000005, 32'h0},
      {1'b0, 4'd3,  32'h0,        32'h0000000A},
      {1'b1, 4'd2,  32'h00000030, 32'h0},
      {1'b0, 4'd2,  32'h0,        32'h0000003A},
      {1'b1, 4'd5,  32'hA5A50000, 32'h0},
      {1'b0, 4'd4,  32'h0,        32'hA5A50000},
      {1'b1, 4'd6,  32'h80800000, 32'h0},
      {1'b0, 4'd4,  32'h0,        32'h25250000},
      {1'b1, 4'd4,  32'hFFFFFFFF, 32'h0},
      {1'b0, 4'd4,  32'h0,        32'h25250000},
      {1'b0, 4'd7,  32'h0,        32'h0},
      {1'b0, 4'd15, 32'h0,        32'h0}
   };

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12 reset state
      chk("R12 rdata after reset", bus_rdata, 32'h0);
      chk("R12 irq after reset", {31'b0, irq}, 32'h0);
      chk("R12 gpio_out after reset", gpio_out, 32'h0);
      chk("R12 cmd_pulse after reset", {31'b0, cmd_pulse}, 32'h0);
      rd_chk("R12 flags after reset", 6'd1, 32'h0);

      // table: R3 R4 R9 R5 R12
      for (int i = 0; i < NV; i++) begin
         if (TBL[i][68]) wr({2'b00, TBL[i][67:64]}, TBL[i][63:32]);
         else begin
            rd({2'b00, TBL[i][67:64]}, v);
            chk($sformatf("R3/R4/R5/R9/R12 table row %0d", i), v, TBL[i][31:0]);
         end
      end
      chk("R4 gpio_out follows word", gpio_out, 32'h25250000);

      // R1 write-one-to-clear
      irq_pulse(8'h13);
      rd_chk("R1 flags raised", 6'd1, 32'h13);
      wr(6'd1, 32'h01);
      rd_chk("R1 only ones cleared", 6'd1, 32'h12);
      // R2 set beats clear in the same cycle
      hw_irq_set = 8'h02;
      wr(6'd1, 32'h12);
      hw_irq_set = '0;
      rd_chk("R2 set wins collision", 6'd1, 32'h02);
      wr(6'd1, 32'h02);
      rd_chk("R1 all cleared", 6'd1, 32'h0);

      // R10 interrupt gating (enables are 0x3A)
      irq_pulse(8'h08);
      chk("R10 gated by global enable", {31'b0, irq}, 32'h0);
      wr(6'd0, 32'h1);
      chk("R10 irq asserted", {31'b0, irq}, 32'h1);
      wr(6'd3, 32'h08);
      chk("R10 irq drops on enable clear", {31'b0, irq}, 32'h0);
      irq_pulse(8'h04);
      chk("R10 unenabled flag no irq", {31'b0, irq}, 32'h0);
      wr(6'd2, 32'h04);
      chk("R10 irq on enable set", {31'b0, irq}, 32'h1);

      // R5 doorbell
      chk("R5 no pulse before write", {31'b0, cmd_pulse}, 32'h0);
      wr(6'd7, 32'h00001234);
      chk("R5 pulse after write", {31'b0, cmd_pulse}, 32'h1);
      @(negedge clk);
      chk("R5 pulse one cycle", {31'b0, cmd_pulse}, 32'h0);
      rd_chk("R5 doorbell reads zero", 6'd7, 32'h0);

      // R6 receive queue
      rd_chk("R6 empty read zero", 6'd8, 32'h0);
      rd_chk("R6 empty level", 6'd9, 32'h0);
      push(8'h11); push(8'h22); push(8'h33);
      rd_chk("R6 level three", 6'd9, 32'h3);
      wr(6'd9, 32'hFF);
      rd_chk("R9 level write ignored", 6'd9, 32'h3);
      rd_chk("R6 pop oldest", 6'd8, 32'h11);
      rd_chk("R6 pop second", 6'd8, 32'h22);
      push(8'h44); push(8'h55); push(8'h66); push(8'h77); push(8'h88);
      rd_chk("R6 level full", 6'd9, 32'h4);
      rd_chk("R6 pop 33", 6'd8, 32'h33);
      rd_chk("R6 pop 44", 6'd8, 32'h44);
      rd_chk("R6 pop 55", 6'd8, 32'h55);
      rd_chk("R6 pop 66 overflow dropped", 6'd8, 32'h66);
      rd_chk("R6 empty again", 6'd8, 32'h0);
      rd_chk("R6 level zero", 6'd9, 32'h0);

      // R7 counter snapshot
      cnt_inc = 1'b1; repeat (7) @(negedge clk); cnt_inc = 1'b0;
      rd_chk("R7 count captured", 6'd10, 32'd7);
      cnt_inc = 1'b1; repeat (5) @(negedge clk); cnt_inc = 1'b0;
      rd_chk("R7 snapshot stable", 6'd11, 32'd7);
      wr(6'd11, 32'hFFFF);
      rd_chk("R9 snapshot write ignored", 6'd11, 32'd7);
      cnt_inc = 1'b1;
      rd_chk("R7 read while counting", 6'd10, 32'd12);
      cnt_inc = 1'b0;
      rd_chk("R7 snapshot of running read", 6'd11, 32'd12);
      rd_chk("R7 counter moved on", 6'd10, 32'd13);

      // R8 read-clear event word
      evt_pulse(8'h05);
      rd_chk("R8 events visible", 6'd12, 32'h05);
      rd_chk("R8 cleared by read", 6'd12, 32'h0);
      hw_evt = 8'h40;
      rd_chk("R8 read in event cycle", 6'd12, 32'h0);
      hw_evt = '0;
      rd_chk("R8 same-cycle event kept", 6'd12, 32'h40);
      evt_pulse(8'h02);
      wr(6'd12, 32'hFF);
      rd_chk("R9 event write ignored", 6'd12, 32'h02);

      // R11 soft reset
      push(8'h99);
      chk("R11 irq before soft reset", {31'b0, irq}, 32'h1);
      wr(6'd0, 32'h3);
      rd_chk("R11 reset bit visible", 6'd0, 32'h3);
      rd_chk("R11 reset bit self-cleared", 6'd0, 32'h0);
      chk("R11 gpio_out cleared", gpio_out, 32'h0);
      chk("R11 irq cleared", {31'b0, irq}, 32'h0);
      rd_chk("R11 flags cleared", 6'd1, 32'h0);
      rd_chk("R11 enables cleared", 6'd2, 32'h0);
      rd_chk("R11 queue cleared", 6'd9, 32'h0);
      rd_chk("R11 counter cleared", 6'd10, 32'h0);
      rd_chk("R11 snapshot cleared", 6'd11, 32'h0);
      rd_chk("R11 events cleared", 6'd12, 32'h0);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule